// File: doc/BRIEF.md
# Framebuffer Fetch Shifter with Host Write Arbitration

This block sits between a video timing generator, a byte-wide static RAM holding a one-bit-per-pixel framebuffer, and a host processor. Every dot-clock slot of eight clocks, it reads one byte from the RAM and then turns that byte into a serial pixel stream. It reads at an address made from the current display line and the byte column taken from the horizontal dot counter. Fetching never stops: all slots of every line are read, including those that fall in sync and border time. Those pixels are simply hidden by the blanking input when the output code is formed.

The host writes the same RAM directly. A write request is answered by a wait signal that stretches the host bus cycle until the next part of a slot that the video read does not use. The write strobe is placed in the middle of that window. The serial pixel is then combined with the sync and blank inputs into a two-bit level code that drives a resistor network for the composite signal.

Top module: `fbf_top`

## Requirements
- R1: While reset is held, and before the first slot completes, `sram_we_n` is 1, `sram_wdrv` is 0, `cpu_wait` is 0 with no request, and `vid_code` is 01 (black).
- R2: In slot phases 0 to 3 (phase = `h_count[2:0]`), `sram_oe_n` is 0 and `sram_addr` equals {`line_idx`, `h_count[9:3]`}. In phases 4 to 7, `sram_oe_n` is 1.
- R3: The byte on `sram_rdata` in phase 3 of slot k is shown during slot k+1, most significant bit first. The pixel at dot 8(k+1)+j is bit 7-j of that byte. The byte from slot 127 is shown in slot 0 of the following line.
- R4: A granted write drives `sram_addr` = `cpu_addr`, `sram_wdata` = `cpu_wdata` and `sram_wdrv` = 1 in phases 4, 5 and 6 of one slot. `sram_we_n` is 0 for exactly one clock, in phase 5.
- R5: `sram_we_n` is never 0 in phases 0 to 4, 6 or 7, and `sram_oe_n` and `sram_we_n` are never 0 together.
- R6: `cpu_wait` is 1 from the cycle `cpu_req` rises until the phase-7 cycle that follows the strobe, where it falls. A request first seen in phase 0 to 4 is written in the same slot. A request first seen in phase 5 to 7 is written in the next slot.
- R7: A request held after its write completes causes no further strobe. A new write needs `cpu_req` to return to 0 for at least one clock first.
- R8: `vid_code` is 00 while `sync_on` is 1. Otherwise it is 01 when `blank_on` is 1 or the pixel is 0, and 11 when the pixel is 1 (a 1 bit is white).
- R9: Reads in phases 0 to 3 continue unchanged while `blank_on` or `sync_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz dot clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_count | input | 10 | Dot position in the line, 0 to 1023 |
| line_idx | input | 8 | Display line, upper RAM address bits |
| sync_on | input | 1 | Sync interval active |
| blank_on | input | 1 | Blanking interval active |
| cpu_req | input | 1 | Host write request, held until wait drops |
| cpu_addr | input | 15 | Host write address |
| cpu_wdata | input | 8 | Host write data |
| cpu_wait | output | 1 | Stretches the host bus cycle |
| sram_addr | output | 15 | RAM address |
| sram_rdata | input | 8 | RAM read data |
| sram_wdata | output | 8 | RAM write data |
| sram_wdrv | output | 1 | Enables the write data drivers |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| vid_code | output | 2 | Level code: 00 sync, 01 black, 11 white |

## Verification
The bench builds the block with its default parameters: 8-bit lines, 128 bytes per line and 8 pixels per byte. This gives full 1024-dot lines, so the bench can reach the wrap from byte 127 of one line into slot 0 of the next. Host requests are launched in phases 0, 3, 4, 5 and 7. These cover the same-slot grant, the longest stall into the next slot, and a request that is still held after its strobe. A RAM model answers reads with a pattern built from the address, so a wrong line or column shows up as a wrong pixel.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    typedef enum logic [1:0] {
        VC_SYNC  = 2'b00,
        VC_BLACK = 2'b01,
        VC_WHITE = 2'b11
    } vcode_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_STB,
        W_HOLD,
        W_DONE
    } wr_state_t;

endpackage

// File: rtl/fbf_slot_dec.sv
// Splits each pixel-byte slot into a read half and a host-write window.
module fbf_slot_dec #(
    parameter int PIX_W = 8,
    localparam int PH_W = $clog2(PIX_W)
) (
    input  logic [PH_W-1:0] phase,
    output logic            rd_phase,
    output logic            latch_en,
    output logic            setup_ph,
    output logic            load_en
);
    localparam int HALF     = PIX_W / 2;
    localparam int PH_LATCH = HALF - 1;
    localparam int PH_SETUP = HALF;
    localparam int PH_LOAD  = PIX_W - 1;

    always_comb begin
        rd_phase = (int'(phase) < HALF);
        latch_en = (int'(phase) == PH_LATCH);
        setup_ph = (int'(phase) == PH_SETUP);
        load_en  = (int'(phase) == PH_LOAD);
    end
endmodule

// File: rtl/fbf_wr_arb.sv
// Grants one host write per request inside the free part of a slot.
module fbf_wr_arb
    import fbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic setup_ph,
    output logic wr_drive,
    output logic wr_strobe,
    output logic cpu_wait
);
    typedef struct packed {
        wr_state_t st;
    } arb_t;

    arb_t arb_d, arb_q;
    logic grant_now;

    always_comb begin
        arb_d     = arb_q;
        grant_now = (arb_q.st == W_IDLE) && cpu_req && setup_ph;
        case (arb_q.st)
            W_IDLE:  if (grant_now) arb_d.st = W_STB;
            W_STB:   arb_d.st = W_HOLD;
            W_HOLD:  arb_d.st = W_DONE;
            W_DONE:  if (!cpu_req) arb_d.st = W_IDLE;
            default: arb_d.st = W_IDLE;
        endcase
        wr_drive  = grant_now || (arb_q.st == W_STB) || (arb_q.st == W_HOLD);
        wr_strobe = (arb_q.st == W_STB);
        cpu_wait  = cpu_req && (arb_q.st != W_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '{st: W_IDLE};
        else        arb_q <= arb_d;
    end

    // R6: wait is only released two clocks after a strobe
    assert_wait_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_wait) && cpu_req) |-> $past(wr_strobe, 2));

    // R7: a released but still-held request never strobes again
    assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_wait) |-> !wr_strobe);
endmodule

// File: rtl/fbf_shifter.sv
// Holds the fetched byte, then shifts it out MSB first.
module fbf_shifter #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic             load_en,
    input  logic [PIX_W-1:0] rdata,
    output logic             pix
);
    typedef struct packed {
        logic [PIX_W-1:0] rd_buf;
        logic [PIX_W-1:0] shreg;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (latch_en) sh_d.rd_buf = rdata;
        if (load_en)  sh_d.shreg  = sh_q.rd_buf;
        else          sh_d.shreg  = {sh_q.shreg[PIX_W-2:0], 1'b0};
        pix = sh_q.shreg[PIX_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R3: a loaded byte reaches the output on the next clock
    assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pix == $past(sh_q.rd_buf[PIX_W-1])));
endmodule

// File: rtl/fbf_mix.sv
// Forms the two-bit composite level code.
module fbf_mix
    import fbf_pkg::*;
(
    input  logic       pix,
    input  logic       sync_on,
    input  logic       blank_on,
    output logic [1:0] code
);
    vcode_t lvl;

    always_comb begin
        if (sync_on)                lvl = VC_SYNC;
        else if (blank_on || !pix)  lvl = VC_BLACK;
        else                        lvl = VC_WHITE;
        code = lvl;
    end
endmodule

// File: rtl/fbf_top.sv
module fbf_top #(
    parameter int LINE_W = 8,
    parameter int BYTE_W = 7,
    parameter int PIX_W  = 8,
    localparam int PH_W  = $clog2(PIX_W),
    localparam int H_W   = BYTE_W + PH_W,
    localparam int A_W   = LINE_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    h_count,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              sync_on,
    input  logic              blank_on,
    input  logic              cpu_req,
    input  logic [A_W-1:0]    cpu_addr,
    input  logic [PIX_W-1:0]  cpu_wdata,
    output logic              cpu_wait,
    output logic [A_W-1:0]    sram_addr,
    input  logic [PIX_W-1:0]  sram_rdata,
    output logic [PIX_W-1:0]  sram_wdata,
    output logic              sram_wdrv,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [1:0]        vid_code
);
    localparam int PH_STB = PIX_W / 2 + 1;

    logic [PH_W-1:0] phase;
    logic rd_phase, latch_en, setup_ph, load_en;
    logic wr_drive, wr_strobe, pix;

    assign phase = h_count[PH_W-1:0];

    fbf_slot_dec #(.PIX_W(PIX_W)) u_dec (
        .phase    (phase),
        .rd_phase (rd_phase),
        .latch_en (latch_en),
        .setup_ph (setup_ph),
        .load_en  (load_en)
    );

    fbf_wr_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .setup_ph  (setup_ph),
        .wr_drive  (wr_drive),
        .wr_strobe (wr_strobe),
        .cpu_wait  (cpu_wait)
    );

    fbf_shifter #(.PIX_W(PIX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .load_en  (load_en),
        .rdata    (sram_rdata),
        .pix      (pix)
    );

    fbf_mix u_mix (
        .pix      (pix),
        .sync_on  (sync_on),
        .blank_on (blank_on),
        .code     (vid_code)
    );

    always_comb begin
        if (wr_drive) sram_addr = cpu_addr;
        else          sram_addr = {line_idx, h_count[H_W-1:PH_W]};
        sram_wdata = cpu_wdata;
        sram_wdrv  = wr_drive;
        sram_oe_n  = !rd_phase;
        sram_we_n  = !wr_strobe;
    end

    // R5: read and write enables are never active together
    assert_no_bus_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    // R5: the strobe only falls in the strobe phase
    assert_strobe_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (int'(phase) == PH_STB));

    // R4: the strobe lasts one clock
    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);
endmodule

// File: tb/tb_fbf_top.sv
module tb_fbf_top;
    logic        clk = 0;
    logic        rst_n;
    logic [9:0]  h_r;
    logic [7:0]  ln;
    logic        run;
    logic        sync_on, blank_on, cpu_req;
    logic [14:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wait;
    logic [14:0] sram_addr;
    logic [7:0]  sram_rdata, sram_wdata;
    logic        sram_wdrv, sram_oe_n, sram_we_n;
    logic [1:0]  vid_code;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ a[14:7];
    endfunction

    assign sram_rdata = pat(sram_addr);

    fbf_top dut (
        .clk(clk), .rst_n(rst_n), .h_count(h_r), .line_idx(ln),
        .sync_on(sync_on), .blank_on(blank_on), .cpu_req(cpu_req),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait),
        .sram_addr(sram_addr), .sram_rdata(sram_rdata), .sram_wdata(sram_wdata),
        .sram_wdrv(sram_wdrv), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .vid_code(vid_code)
    );

    // timing generator model: advances at the falling edge
    always @(negedge clk) begin
        if (run) begin
            h_r <= h_r + 10'd1;
            if (h_r == 10'd1023) ln <= ln + 8'd1;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #5;
    endtask

    task automatic t_reset();
        rst_n = 0; run = 0; h_r = 0; ln = 0;
        sync_on = 0; blank_on = 0; cpu_req = 0; cpu_addr = 0; cpu_wdata = 0;
        repeat (3) tick();
        chk("R1 we_n", sram_we_n, 1);
        chk("R1 wdrv", sram_wdrv, 0);
        chk("R1 wait", cpu_wait, 0);
        chk("R1 code", vid_code, 2'b01);
        @(negedge clk);
        rst_n = 1; run = 1;
        #5;
        repeat (4) begin
            tick();
            chk("R1 code after reset", vid_code, 2'b01);
        end
    endtask

    task automatic t_fetch(input logic blank);
        blank_on = blank;
        while (h_r[2:0] != 3'd1) tick();
        chk("R2 addr", sram_addr, {ln, h_r[9:3]});
        chk(blank ? "R9 oe during blank" : "R2 oe", sram_oe_n, 0);
        while (h_r[2:0] != 3'd3) tick();
        chk("R2 addr ph3", sram_addr, {ln, h_r[9:3]});
        while (h_r[2:0] != 3'd5) tick();
        chk("R2 oe off", sram_oe_n, 1);
        if (blank) chk("R8 blank code", vid_code, 2'b01);
        blank_on = 0;
    endtask

    task automatic t_pixels(input int slot);
        logic [7:0] b;
        logic [7:0] fl;
        while (h_r != 10'(8 * slot)) tick();
        fl = (slot == 0) ? ln - 8'd1 : ln;
        b = pat({fl, 7'((slot + 127) % 128)});
        for (int j = 0; j < 8; j++) begin
            chk("R3 pixel", vid_code, b[7-j] ? 2'b11 : 2'b01);
            tick();
        end
    endtask

    task automatic t_mix();
        while (h_r[2:0] != 3'd2) tick();
        sync_on = 1;
        #1 chk("R8 sync", vid_code, 2'b00);
        blank_on = 1;
        #1 chk("R8 sync over blank", vid_code, 2'b00);
        chk("R9 oe during sync", sram_oe_n, 0);
        sync_on = 0;
        #1 chk("R8 blank", vid_code, 2'b01);
        blank_on = 0;
    endtask

    task automatic t_write(input int p, input logic [14:0] a, input logic [7:0] d);
        int s;
        s = (p <= 4) ? 4 - p : 12 - p;
        while (int'(h_r[2:0]) != p) tick();
        cpu_req = 1; cpu_addr = a; cpu_wdata = d;
        #1;
        for (int c = 0; c < s + 14; c++) begin
            if (c > 0) tick();
            chk("R4 R7 we_n", sram_we_n, (c == s + 1) ? 0 : 1);
            chk("R6 wait", cpu_wait, (c < s + 3) ? 1 : 0);
            if (c >= s && c <= s + 2) begin
                chk("R4 addr", sram_addr, a);
                chk("R4 wdata", sram_wdata, d);
                chk("R4 wdrv", sram_wdrv, 1);
            end else begin
                chk("R4 wdrv off", sram_wdrv, 0);
            end
        end
        cpu_req = 0;
        tick();
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_fetch(0);
        t_fetch(1);
        t_pixels(20);
        t_pixels(71);
        t_pixels(0);
        t_mix();
        t_write(0, 15'h1234, 8'hA5);
        t_write(3, 15'h7FFF, 8'h3C);
        t_write(4, 15'h0001, 8'hFF);
        t_write(5, 15'h4000, 8'h00);
        t_write(7, 15'h2AAA, 8'h81);
        t_fetch(0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule